// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block turns a fan's tachometer signal into an 8-bit speed figure. A revolution is taken as two rising tach edges. Across that window a counter advances on ticks of a prescaled reference clock. The counter starts from a configurable preload value. When the window closes, the total is latched and a one-cycle valid strobe is raised. A slower fan gives a larger figure, so halving the fan speed roughly doubles the ticks counted.

The prescaler divides the reference clock by 1, 2, 4 or 8. Moving up one divisor step halves the fan speed that gives a particular count. When the counter reaches 255 before the window closes, it stops there and reports 255. It also raises a stall flag. The next tach edge starts a fresh measurement.

A small synchronous configuration port writes the preload and the divisor code. Both default to the common setting after reset.

Top module: `fan_tach_counter`

## Requirements
- R1: After reset `meas_count` is 0, `meas_valid` is 0 and `fan_stall` is 0. The divisor code is 1 (divide by 2) and the preload is 32.
- R2: While `cfg_we` is high, a clock edge captures `cfg_preload` and `cfg_div`. While `cfg_we` is low, both inputs have no effect. The divisor codes 0, 1, 2 and 3 select divide by 1, 2, 4 and 8.
- R3: The first rising tach edge after reset starts a window. The rising edge in the middle of a window produces no strobe and no change on `meas_count`.
- R4: A window that spans S reference cycles between its first and third rising tach edges reports `preload + floor((S-1)/D)`, where D is the selected divisor. `meas_valid` is high in the cycle after the third clock edge, counting from the edge that first samples the closing tach high (two-flop synchronizer plus edge detector).
- R5: For the same count, each doubling of D halves the tach rate.
- R6: `meas_valid` lasts exactly one cycle. The edge that closes a window also opens the next window, so windows run back to back.
- R7: If the counter reaches 255 inside a window, then on the next cycle `meas_count` becomes 255, `meas_valid` pulses and `fan_stall` goes high. The counter then holds and gives no further strobe until a tach edge arrives. When saturation and the window's closing edge fall on the same cycle, saturation wins.
- R8: After saturation, the next rising tach edge restarts a window. `fan_stall` stays high until a window completes below 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| cfg_we | input | 1 | Configuration write enable |
| cfg_div | input | 2 | Divisor code to write (0:/1, 1:/2, 2:/4, 3:/8) |
| cfg_preload | input | 8 | Preload value to write |
| meas_count | output | 8 | Latched revolution count |
| meas_valid | output | 1 | One-cycle strobe for a new count |
| fan_stall | output | 1 | Set on saturation, cleared by a good window |

## Verification
A prescaler phase that is not cleared at window start, or a half-revolution flag that is lost, shifts the latched count by one or more ticks. This shows on `meas_count` at the very next strobe, three cycles after the closing edge. A saturation state that fails to hold shows as an extra strobe, or as a count below 255 while `fan_stall` is high, within one prescaled tick. A stall flag that clears too early shows at the half-revolution edge that follows a restart.

// File: rtl/fan_tach_pkg.sv
// Package: shared constants, divisor encoding and mask helper for the
// fan tachometer counter. Assumes the divisor is a power of two, 1..8.
package fan_tach_pkg;
    localparam int DIV_SEL_W = 2;
    localparam int PRE_W     = (1 << DIV_SEL_W) - 1;

    typedef enum logic [DIV_SEL_W-1:0] {
        DIV_BY_1 = 2'd0,
        DIV_BY_2 = 2'd1,
        DIV_BY_4 = 2'd2,
        DIV_BY_8 = 2'd3
    } div_code_e;

    // Terminal value of the prescaler for a divisor code: 2**sel - 1.
    function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_SEL_W-1:0] sel);
        logic [PRE_W:0] w;
        w = ({{PRE_W{1'b0}}, 1'b1} << sel) - 1'b1;
        return w[PRE_W-1:0];
    endfunction
endpackage

// File: rtl/tach_edge_sync.sv
// Synchronizes the asynchronous tach input through STAGES flops and emits
// a one-cycle pulse on each rising edge. Assumes tach levels last at least
// one reference cycle.
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the tach level through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], d_async};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R4: an edge pulse never lasts two cycles
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tach_tick_gen.sv
// Prescaler: raises tick once every 2**sel cycles. The phase restarts when
// clr is high, so a window's first tick falls a full period after its start.
// Assumes sel is changed only between windows.
module tach_tick_gen
    import fan_tach_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [DIV_SEL_W-1:0] sel,
    output logic                 tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(sel);
    assign tick = (pre_q == mask);

    // Advance the prescaler phase, wrap at the mask, restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pre_q <= '0;
        else if (tick)      pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // R2: with any divisor above one, ticks are never adjacent
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || sel == DIV_BY_1));
endmodule

// File: rtl/tach_window_counter.sv
// Window state machine: a first rising edge arms, the second marks half a
// revolution, and the third closes the window and latches the count. The
// count then reloads from the preload. Saturation at the maximum holds the
// counter and sets a sticky stall flag. Assumes rise pulses are one cycle.
module tach_window_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             tick,
    input  logic [CNT_W-1:0] preload,
    output logic             start_win,
    output logic [CNT_W-1:0] count_out,
    output logic             valid,
    output logic             stall
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SAT} win_state_e;

    win_state_e       state_q;
    logic             half_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] out_q;
    logic             valid_q;
    logic             stall_q;
    logic             at_max;

    assign at_max    = (cnt_q == CNT_MAX);
    assign start_win = rise && (state_q != ST_RUN || (half_q && !at_max));

    // Sequence windows, count ticks, latch results and track saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            cnt_q   <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rise) begin
                        state_q <= ST_RUN;
                        cnt_q   <= preload;
                        half_q  <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (at_max) begin
                        state_q <= ST_SAT;
                        out_q   <= CNT_MAX;
                        valid_q <= 1'b1;
                        stall_q <= 1'b1;
                    end else if (rise && half_q) begin
                        out_q   <= cnt_q;
                        valid_q <= 1'b1;
                        stall_q <= 1'b0;
                        cnt_q   <= preload;
                        half_q  <= 1'b0;
                    end else begin
                        if (rise) half_q <= 1'b1;
                        if (tick) cnt_q  <= cnt_q + CNT_ONE;
                    end
                end
                ST_SAT: begin
                    if (rise) begin
                        state_q <= ST_RUN;
                        cnt_q   <= preload;
                        half_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign count_out = out_q;
    assign valid     = valid_q;
    assign stall     = stall_q;

    // R6: the strobe is a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R7: a raised stall always reports the maximum
    a_r7_stall_max: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q |-> out_q == CNT_MAX);
    // R7: saturation holds until a tach edge arrives
    a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT && !rise) |=> (state_q == ST_SAT && cnt_q == CNT_MAX));
    // R8: a good window never reports the maximum
    a_r8_good_below_max: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !stall_q) |-> out_q != CNT_MAX);
endmodule

// File: rtl/fan_tach_counter.sv
// Top: holds the preload and divisor configuration, and joins the tach
// synchronizer, the prescaler and the window counter. Configuration writes
// are synchronous. A divisor change takes effect at once, so it belongs
// between windows.
module fan_tach_counter
    import fan_tach_pkg::*;
#(
    parameter int          CNT_W       = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          DEF_PRELOAD = 32,
    parameter div_code_e   DEF_DIV     = DIV_BY_2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tach_in,
    input  logic                 cfg_we,
    input  logic [DIV_SEL_W-1:0] cfg_div,
    input  logic [CNT_W-1:0]     cfg_preload,
    output logic [CNT_W-1:0]     meas_count,
    output logic                 meas_valid,
    output logic                 fan_stall
);
    logic [CNT_W-1:0]     preload_q;
    logic [DIV_SEL_W-1:0] div_q;
    logic                 rise;
    logic                 tick;
    logic                 start_win;

    // Capture configuration on write enable; reset to the default setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= CNT_W'(DEF_PRELOAD);
            div_q     <= DEF_DIV;
        end else if (cfg_we) begin
            preload_q <= cfg_preload;
            div_q     <= cfg_div;
        end
    end

    tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (tach_in),
        .rise    (rise)
    );

    tach_tick_gen u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_win),
        .sel   (div_q),
        .tick  (tick)
    );

    tach_window_counter #(.CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .tick      (tick),
        .preload   (preload_q),
        .start_win (start_win),
        .count_out (meas_count),
        .valid     (meas_valid),
        .stall     (fan_stall)
    );

    // R2: configuration changes only under write enable
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(preload_q) && $stable(div_q)));
endmodule

// File: tb/tb_fan_tach_counter.sv
module tb_fan_tach_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tach_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_div = 2'd0;
    logic [7:0] cfg_preload = 8'd0;
    logic [7:0] meas_count;
    logic       meas_valid;
    logic       fan_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fan_tach_counter dut (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .cfg_we(cfg_we),
        .cfg_div(cfg_div), .cfg_preload(cfg_preload),
        .meas_count(meas_count), .meas_valid(meas_valid), .fan_stall(fan_stall)
    );

    // Vectors: divisor code, preload, tach period (cycles), count, stall.
    localparam int VN = 9;
    localparam int V_DIV [VN] = '{1, 0, 2, 3, 1, 1, 0, 0, 0};
    localparam int V_PRE [VN] = '{32, 32, 32, 32, 0, 100, 200, 200, 32};
    localparam int V_PER [VN] = '{112, 56, 224, 448, 20, 50, 27, 28, 3};
    localparam int V_CNT [VN] = '{143, 143, 143, 143, 19, 149, 253, 255, 37};
    localparam int V_STL [VN] = '{0, 0, 0, 0, 0, 0, 0, 1, 0};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input int dv, input int pl);
        cfg_we = 1'b1; cfg_div = 2'(dv); cfg_preload = 8'(pl);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // n rising edges p cycles apart; returns two negedges after the last rise.
    task automatic send(input int n, input int p);
        for (int i = 0; i < n; i++) begin
            tach_in = 1'b1;
            @(negedge clk); @(negedge clk);
            tach_in = 1'b0;
            if (i != n - 1) repeat (p - 2) @(negedge clk);
        end
    endtask

    initial begin
        int n;
        bit seen;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 count", meas_count, 0);
        chk("R1 valid", meas_valid, 0);
        chk("R1 stall", fan_stall, 0);
        // R1: defaults /2 and preload 32: S=112 -> 32+111/2 = 87
        send(3, 56);
        @(negedge clk);
        chk("R1 default count", meas_count, 87);
        chk("R4 valid timing", meas_valid, 1);

        // R4 R5 R7: table walk, each from reset
        for (int v = 0; v < VN; v++) begin
            do_reset();
            cfg_write(V_DIV[v], V_PRE[v]);
            send(3, V_PER[v]);
            @(negedge clk);
            chk(V_STL[v] != 0 ? "R7 sat wins" : (v < 4 ? "R5 scale" : "R4 count"),
                meas_count, V_CNT[v]);
            chk("R4 valid", meas_valid, 1);
            chk("R7 stall", fan_stall, V_STL[v]);
            @(negedge clk);
            chk("R6 one cycle", meas_valid, 0);
        end

        // R7: saturation at /8, preload 32, single edge
        do_reset();
        cfg_write(3, 32);
        send(1, 10);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!meas_valid && n < 3000);
        chk("R7 sat cycle", n, 1786);
        chk("R7 sat count", meas_count, 255);
        chk("R7 stall set", fan_stall, 1);
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (meas_valid) seen = 1'b1;
        end
        chk("R7 no more strobe", seen, 0);
        chk("R7 stall held", fan_stall, 1);

        // R8: restart, stall stays until a good window; R3 mid edge quiet
        cfg_write(1, 32);
        send(2, 40);
        @(negedge clk);
        chk("R3 mid edge quiet", meas_valid, 0);
        chk("R8 stall sticky", fan_stall, 1);
        repeat (37) @(negedge clk);
        send(1, 40);
        @(negedge clk);
        chk("R8 good count", meas_count, 71);
        chk("R8 stall cleared", fan_stall, 0);
        @(negedge clk);
        chk("R6 one cycle", meas_valid, 0);

        // R6: closing edge opens next window, S=60 -> 32+59/2 = 61
        repeat (26) @(negedge clk);
        send(2, 30);
        @(negedge clk);
        chk("R6 back to back", meas_count, 61);

        // R2: config inputs ignored without write enable
        cfg_div = 2'd0; cfg_preload = 8'd99;
        repeat (27) @(negedge clk);
        send(2, 30);
        @(negedge clk);
        chk("R2 cfg ignored", meas_count, 61);

        // R1: reset while running
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rerun count", meas_count, 0);
        chk("R1 rerun stall", fan_stall, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule